// File: doc/BRIEF.md
# Memory-Card Command Line Shifter

This block is the host side of the serial command channel of a memory card. One operation shifts a host command of any bit length out on the bidirectional CMD line. A second operation then captures the card's reply from the same line. Software exchanges the bits one 32-bit word at a time through a single holding register. Two flags tell software when to act: one says the register can take a word, the other says a received word is waiting.

A control word sets up each operation. It carries the bit count, the direction, and two masks. The masks decide whether CMD and the DATA lines are driven high or left floating once the operation ends. The first word of any transfer holds the leftover bits (count modulo 32), placed at the top of the word. The block generates and checks no CRC, so software places the CRC inside the command bits itself. The serial clock is generated from the system clock and pauses whenever a word is missing mid-command or no room is left mid-response. A busy flag is high while shifting is in progress, and each of its edges sets a sticky event flag.

Top module: `card_cmd_shifter`

## Requirements
- R1: A control write loads count = bits 15:0, transmit direction = bit 17, CMD drive mask = bit 18 and DATA drive mask = bit 19. A nonzero count raises `busy` on the next cycle. A zero count starts nothing and leaves `busy` low.
- R2: In transmit, `cmd_o` presents the bits MSB first. It changes only while `sclk_out` is low and is stable at each rising edge of `sclk_out`.
- R3: The first data word of a transfer carries (count mod 32) bits, or 32 when the count is a multiple of 32, in its upper bits. Every later word carries 32 bits.
- R4: `tx_empty` is high during a transmit whenever the holding register can take a word. A `dat_we` pulse while it is high loads the word.
- R5: In transmit, when the shift register runs out and no word is waiting, `sclk_out` stays low and `busy` stays high until a word is written.
- R6: In receive, `cmd_i` is sampled on the rising edge of `sclk_out`. Leading 1 bits are skipped until the first 0 (start bit). The first word read back is left-justified, with zeros below the remainder bits.
- R7: `rx_full` flags a received word, and a `dat_re` pulse takes it. When the shift register completes a word while the holding register is still full, `sclk_out` stays low until the word is read.
- R8: `cmd_oe` is high throughout a transmit and low throughout a receive.
- R9: When no operation is running, CMD is driven high exactly when the latched bit 18 is set, and the DATA lines are driven high (`dat_oe`) exactly when bit 19 is set. A control word of zero releases both.
- R10: A rise of `busy` sets `irq_busy_rise`, and a fall sets `irq_busy_fall`. Each flag stays set until its `irq_clr` bit (0 = rise, 1 = fall) is pulsed.
- R11: `sclk_out` is low whenever `busy` is low.
- R12: After reset the block is idle: `busy`, `sclk_out`, `cmd_oe`, `dat_oe`, `tx_empty`, `rx_full` and both event flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: count, direction, drive masks |
| dat_we | input | 1 | Holding register write strobe |
| dat_wdata | input | WORD_W | Word to transmit |
| dat_re | input | 1 | Holding register read strobe |
| dat_rdata | output | WORD_W | Received word |
| tx_empty | output | 1 | Holding register can take a transmit word |
| rx_full | output | 1 | Received word waiting |
| busy | output | 1 | Shifting in progress |
| irq_busy_rise | output | 1 | Sticky flag: busy rose |
| irq_busy_fall | output | 1 | Sticky flag: busy fell |
| irq_clr | input | 2 | Clear strobes for the two event flags |
| sclk_out | output | 1 | Serial clock to the card |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input value |
| dat_oe | output | 1 | DATA lines driven high when set |

## Verification
A wrong word-bit counter shifts the first word's remainder into the wrong place. The card-side monitor sees the wrong bit at a rising serial clock edge within a few bits of the fault. A holding-register flag in the wrong state does not show up as a wrong value. Instead the serial clock stalls or keeps running when it should not, and `busy` stays high or falls early. That appears at the next word boundary, and the bench checks it after waiting longer than one word takes. Wrong drive masks or direction show at `cmd_oe` and `dat_oe` as soon as `busy` changes.

// File: rtl/card_cmd_shifter.sv
module card_cmd_shifter #(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 16,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  input  logic              dat_we,
  input  logic [WORD_W-1:0] dat_wdata,
  input  logic              dat_re,
  output logic [WORD_W-1:0] dat_rdata,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              busy,
  output logic              irq_busy_rise,
  output logic              irq_busy_fall,
  input  logic [1:0]        irq_clr,
  output logic              sclk_out,
  output logic              cmd_o,
  output logic              cmd_oe,
  input  logic              cmd_i,
  output logic              dat_oe
);
  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam int BW        = $clog2(WORD_W + 1);
  localparam int LW        = $clog2(WORD_W);
  localparam int DIR_BIT   = 17;
  localparam int CMASK_BIT = 18;
  localparam int DMASK_BIT = 19;

  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt;
  logic [BW-1:0]     wbits, wsize, first_size;
  logic [WORD_W-1:0] sh, hold, sh_in;
  logic              hold_full, tx_mode, started, pend, cmask, dmask, busy_q;
  logic              tick;

  assign tick       = (div_q == DIV_W'(HALF_DIV - 1));
  assign first_size = (ctl_wdata[LW-1:0] == '0) ? BW'(WORD_W) : BW'(ctl_wdata[LW-1:0]);
  assign sh_in      = {sh[WORD_W-2:0], cmd_i};

  assign tx_empty  = busy & tx_mode & ~hold_full;
  assign rx_full   = ~tx_mode & hold_full;
  assign dat_rdata = hold;
  assign cmd_o     = busy ? sh[WORD_W-1] : 1'b1;
  assign cmd_oe    = busy ? tx_mode : cmask;
  assign dat_oe    = ~busy & dmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; cnt <= '0; wbits <= '0; wsize <= '0;
      sh <= '1; hold <= '0; hold_full <= 1'b0; tx_mode <= 1'b0;
      started <= 1'b0; pend <= 1'b0; cmask <= 1'b0; dmask <= 1'b0;
      busy <= 1'b0; sclk_out <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (ctl_we) begin
        cnt       <= ctl_wdata[CNT_W-1:0];
        tx_mode   <= ctl_wdata[DIR_BIT];
        cmask     <= ctl_wdata[CMASK_BIT];
        dmask     <= ctl_wdata[DMASK_BIT];
        busy      <= |ctl_wdata[CNT_W-1:0];
        wsize     <= first_size;
        wbits     <= '0;
        hold_full <= 1'b0;
        pend      <= 1'b0;
        started   <= 1'b0;
        sclk_out  <= 1'b0;
        sh        <= '1;
      end else begin
        if (dat_we && tx_empty) begin
          hold      <= dat_wdata;
          hold_full <= 1'b1;
        end
        if (dat_re && rx_full) hold_full <= 1'b0;
        if (busy && tick) begin
          if (tx_mode) begin
            if (sclk_out) begin
              sclk_out <= 1'b0;
              cnt      <= cnt - CNT_W'(1);
              if (cnt == CNT_W'(1)) busy <= 1'b0;
              if (wbits == BW'(1) && hold_full && cnt != CNT_W'(1)) begin
                sh <= hold; wbits <= wsize; wsize <= BW'(WORD_W); hold_full <= 1'b0;
              end else begin
                sh <= sh << 1; wbits <= wbits - BW'(1);
              end
            end else if (wbits != '0) begin
              sclk_out <= 1'b1;
            end else if (hold_full) begin
              sh <= hold; wbits <= wsize; wsize <= BW'(WORD_W); hold_full <= 1'b0;
            end
          end else begin
            if (sclk_out) begin
              sclk_out <= 1'b0;
              if (cnt == '0 && !pend) busy <= 1'b0;
            end else if (pend) begin
              if (!hold_full) begin
                hold <= sh << (BW'(WORD_W) - wsize);
                hold_full <= 1'b1; pend <= 1'b0;
                wbits <= '0; wsize <= BW'(WORD_W);
                if (cnt == '0) busy <= 1'b0;
              end
            end else begin
              sclk_out <= 1'b1;
              if (started || !cmd_i) begin
                started <= 1'b1;
                sh      <= sh_in;
                cnt     <= cnt - CNT_W'(1);
                if (wbits + BW'(1) == wsize) begin
                  if (!hold_full) begin
                    hold <= sh_in << (BW'(WORD_W) - wsize);
                    hold_full <= 1'b1; wbits <= '0; wsize <= BW'(WORD_W);
                  end else begin
                    pend <= 1'b1; wbits <= wbits + BW'(1);
                  end
                end else begin
                  wbits <= wbits + BW'(1);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; irq_busy_rise <= 1'b0; irq_busy_fall <= 1'b0;
    end else begin
      busy_q        <= busy;
      irq_busy_rise <= (irq_busy_rise & ~irq_clr[0]) | (busy & ~busy_q);
      irq_busy_fall <= (irq_busy_fall & ~irq_clr[1]) | (~busy & busy_q);
    end
  end
endmodule

// File: rtl/card_cmd_shifter_sva.sv
module card_cmd_shifter_sva #(
  parameter int BW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          tx_mode,
  input logic          sclk_out,
  input logic          cmd_o,
  input logic          cmd_oe,
  input logic          dat_oe,
  input logic          irq_busy_rise,
  input logic          irq_busy_fall,
  input logic [BW-1:0] wbits,
  input logic          pend
);
  assert_cmd_driven_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tx_mode |-> cmd_oe);
  assert_cmd_released_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_mode |-> !cmd_oe);
  assert_idle_cmd_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_oe |-> cmd_o);
  assert_data_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> !busy);
  assert_sclk_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_out);
  assert_tx_no_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) && tx_mode |-> $past(wbits) != '0);
  assert_rx_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) && !tx_mode |-> !$past(pend));
  assert_rise_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> irq_busy_rise);
  assert_fall_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> irq_busy_fall);
endmodule

bind card_cmd_shifter card_cmd_shifter_sva #(.BW(BW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_mode(tx_mode), .sclk_out(sclk_out),
  .cmd_o(cmd_o), .cmd_oe(cmd_oe), .dat_oe(dat_oe), .irq_busy_rise(irq_busy_rise),
  .irq_busy_fall(irq_busy_fall), .wbits(wbits), .pend(pend)
);

// File: tb/card_cmd_shifter_tb.sv
`timescale 1ns/1ps
module card_cmd_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0, cmd_i = 1'b1;
  logic [31:0] ctl_wdata = '0, dat_wdata = '0, dat_rdata;
  logic [1:0]  irq_clr = '0;
  logic        tx_empty, rx_full, busy, irq_busy_rise, irq_busy_fall;
  logic        sclk_out, cmd_o, cmd_oe, dat_oe;

  int errors = 0, checks = 0;
  bit tx_watch = 0, card_on = 0, done = 0;
  bit exp_bits[$];
  bit card_bits[$];
  logic [31:0] exp_words[$];

  always #2.5 clk = ~clk;

  card_cmd_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re), .dat_rdata(dat_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy),
    .irq_busy_rise(irq_busy_rise), .irq_busy_fall(irq_busy_fall), .irq_clr(irq_clr),
    .sclk_out(sclk_out), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i), .dat_oe(dat_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic dat_write(input logic [31:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic push_tx(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) exp_bits.push_back(v[i]);
  endtask

  task automatic push_card(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) card_bits.push_back(v[i]);
  endtask

  task automatic read_word(input string req);
    logic [31:0] e;
    while (!rx_full) @(negedge clk);
    e = (exp_words.size() != 0) ? exp_words.pop_front() : 32'hx;
    dat_re = 1'b1;
    chk(req, dat_rdata, e);
    @(negedge clk); dat_re = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_irqs();
    @(negedge clk); irq_clr = 2'b11;
    @(negedge clk); irq_clr = 2'b00;
  endtask

  always @(posedge sclk_out) begin
    if (tx_watch) begin
      #1;
      if (exp_bits.size() == 0) chk("R2 extra bit", 32'(cmd_o), 32'hx);
      else chk("R2 tx bit", 32'(cmd_o), 32'(exp_bits.pop_front()));
    end
  end

  always @(negedge sclk_out) begin
    if (card_on) begin
      #1;
      cmd_i = (card_bits.size() != 0) ? card_bits.pop_front() : 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 sclk", 32'(sclk_out), 0);
    chk("R12 cmd_oe", 32'(cmd_oe), 0);
    chk("R12 dat_oe", 32'(dat_oe), 0);
    chk("R12 flags", {28'd0, tx_empty, rx_full, irq_busy_rise, irq_busy_fall}, 0);

    // Transmit 40 bits: 8-bit first word, then 32
    tx_watch = 1;
    push_tx(32'hA5, 8);
    push_tx(32'h12345678, 32);
    ctl_write(32'h0006_0000 | 32'd40);
    chk("R1 busy after start", 32'(busy), 1);
    chk("R4 tx_empty", 32'(tx_empty), 1);
    chk("R8 cmd_oe tx", 32'(cmd_oe), 1);
    dat_write(32'hA500_0000);
    repeat (100) @(negedge clk);
    chk("R5 sclk stalled", 32'(sclk_out), 0);
    chk("R5 busy held", 32'(busy), 1);
    chk("R4 tx_empty stalled", 32'(tx_empty), 1);
    chk("R3 remainder bits sent", 32'(exp_bits.size()), 32);
    dat_write(32'h1234_5678);
    wait_idle();
    chk("R2 all bits sent", 32'(exp_bits.size()), 0);
    chk("R9 cmd driven", 32'(cmd_oe), 1);
    chk("R9 cmd high", 32'(cmd_o), 1);
    chk("R9 data released", 32'(dat_oe), 0);
    chk("R11 sclk idle", 32'(sclk_out), 0);
    chk("R10 rise flag", 32'(irq_busy_rise), 1);
    chk("R10 fall flag", 32'(irq_busy_fall), 1);
    clear_irqs();
    chk("R10 flags cleared", {30'd0, irq_busy_rise, irq_busy_fall}, 0);
    tx_watch = 0;

    // Receive 48 bits after three idle ones
    push_card(32'h3, 2);
    push_card(32'h3F12, 16);
    push_card(32'h89AB_CDEF, 32);
    exp_words.push_back(32'h3F12_0000);
    exp_words.push_back(32'h89AB_CDEF);
    card_on = 1;
    ctl_write(32'h0008_0000 | 32'd48);
    chk("R8 cmd_oe rx", 32'(cmd_oe), 0);
    chk("R9 data off while busy", 32'(dat_oe), 0);
    while (!rx_full) @(negedge clk);
    repeat (200) @(negedge clk);
    chk("R7 sclk stalled", 32'(sclk_out), 0);
    chk("R7 busy held", 32'(busy), 1);
    read_word("R6 first word left-justified");
    wait_idle();
    chk("R7 last word waiting", 32'(rx_full), 1);
    read_word("R6 second word");
    chk("R7 rx_full cleared", 32'(rx_full), 0);
    chk("R9 data driven", 32'(dat_oe), 1);
    chk("R9 cmd released", 32'(cmd_oe), 0);
    card_on = 0; cmd_i = 1'b1;

    // Transmit exactly 32 bits, no masks
    tx_watch = 1;
    push_tx(32'hDEAD_BEEF, 32);
    ctl_write(32'h0002_0000 | 32'd32);
    dat_write(32'hDEAD_BEEF);
    wait_idle();
    chk("R3 full first word", 32'(exp_bits.size()), 0);
    chk("R9 no masks cmd", 32'(cmd_oe), 0);
    chk("R9 no masks data", 32'(dat_oe), 0);
    tx_watch = 0;
    clear_irqs();

    // Zero count with masks, then zero control word
    ctl_write(32'h000C_0000);
    chk("R1 zero count idle", 32'(busy), 0);
    chk("R9 both driven", {30'd0, cmd_oe, dat_oe}, 3);
    ctl_write(32'h0);
    chk("R9 both released", {30'd0, cmd_oe, dat_oe}, 0);
    @(negedge clk);
    chk("R1 no rise flag", 32'(irq_busy_rise), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule